// File: doc/BRIEF.md
# Acquire Pair Load Unit

This block executes one instruction word of a load-pair-with-acquire operation. It checks the word against a fixed encoding, reads a base address from the general register file or from the stack pointer, and issues a single 16-byte read. That read carries an acquire attribute and a tag-check attribute, and both depend on the register indices in the word. The 128-bit response is split into two 64-bit halves, in an order set by the endianness input. The halves are then written through two register-file write ports in the same cycle.

The unit handles one instruction at a time. `instr_ready` is high only while the unit is idle, and an instruction is taken on a cycle where both `instr_valid` and `instr_ready` are high. The memory request follows valid/ready rules. Once `mem_req_valid` rises, it stays high with address and attributes unchanged until a cycle where `mem_req_ready` is high, and that cycle is the handshake. The response side has no back-pressure. The unit always accepts `mem_rsp_valid` while it waits for a response, and the memory must not assert it at any other time. Every instruction ends with a one-cycle `done` pulse together with exactly one outcome flag.

The parameter `OVL_MODE` decides what happens when both destination fields name the same register: 0 raises undefined-instruction, 1 completes as a no-op with no memory access, and 2 (the default) performs the access and writes `UNK_VAL` to that register.

Top module: `lpa_unit`

## Requirements
- R1: A word is accepted as the operation only if bits 31:21 are 11011001010 and bits 15:10 are 010110. The fields are: second destination in bits 20:16, base in bits 9:5, first destination in bits 4:0. Any other word completes with `res_undef` and makes no memory request.
- R2: If `feat_en` is low, a matching word completes with `res_undef` and makes no memory request.
- R3: `mem_req_acquire` is 1 exactly when neither destination index is 31.
- R4: If the base index is 31, the request address is `sp_value` and `mem_req_tagchk` is 0. Otherwise the address is the value of register `rf_rd_idx` (the base field) and `mem_req_tagchk` is 1. No offset is added.
- R5: If the base index is 31, `sp_align_en` is 1 and `sp_value[3:0]` is nonzero, the instruction completes with `res_sp_fault` and makes no request. If `sp_align_en` is 0, the access proceeds.
- R6: With `big_endian`=0, the first destination gets response bits 63:0 and the second gets bits 127:64. With `big_endian`=1 the halves are swapped.
- R7: When both destination indices are equal, the instruction follows `OVL_MODE`. With the default (2), the access is made and both write ports carry `UNK_VAL` to that index.
- R8: A response with `mem_rsp_err`=1 completes with `res_bus_fault` and enables no register write.
- R9: Both writes are presented in the cycle after the response is accepted, together with `done` and `res_ok`. A write to index 31 has its enable held low.
- R10: `instr_ready` is high only while idle. A pending request holds its valid, address and attributes stable until `mem_req_ready`.
- R11: Each instruction produces one `done` pulse with exactly one of `res_ok`, `res_nop`, `res_undef`, `res_sp_fault`, `res_bus_fault`. All outcome flags are low when `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Enables the operation; low makes matches undefined |
| big_endian | input | 1 | Selects swapped half order |
| sp_align_en | input | 1 | Enables the 16-byte stack pointer alignment check |
| sp_value | input | 64 | Current stack pointer |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle and able to take a word |
| instr_word | input | 32 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index (base field of `instr_word`) |
| rf_rd_data | input | 64 | Combinational read data for `rf_rd_idx` |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 64 | Byte address of the 16-byte read |
| mem_req_acquire | output | 1 | Acquire ordering attribute |
| mem_req_tagchk | output | 1 | Tag-check attribute |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 128 | Response data |
| mem_rsp_err | input | 1 | Response error |
| wr0_en | output | 1 | First write port enable |
| wr0_idx | output | 5 | First write port index |
| wr0_data | output | 64 | First write port data |
| wr1_en | output | 1 | Second write port enable |
| wr1_idx | output | 5 | Second write port index |
| wr1_data | output | 64 | Second write port data |
| done | output | 1 | Completion pulse |
| res_ok | output | 1 | Completed with writeback |
| res_nop | output | 1 | Completed as no-op |
| res_undef | output | 1 | Undefined instruction |
| res_sp_fault | output | 1 | Stack pointer misaligned |
| res_bus_fault | output | 1 | Memory response error |

## Verification
The assertions assume that the memory returns a response only while the unit waits for one, that it returns at most one response per request, and that `rf_rd_data` is settled in the same cycle as `rf_rd_idx`. The bench models memory inside its scenario tasks. Those tasks raise `mem_rsp_valid` for exactly one cycle, and only after the request handshake has completed. The bench also holds `mem_req_ready` low for one cycle on every access, which exercises the stability rule. It drives `rf_rd_data` as a combinational function of `rf_rd_idx`, so the base read is always consistent with the index.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int unsigned IDXW = 5;
  localparam logic [IDXW-1:0] ZR_IDX = 5'd31;
  localparam logic [10:0] OPC_HI  = 11'b11011001010;
  localparam logic [5:0]  OPC_MID = 6'b010110;

  localparam int unsigned OVL_IS_UNDEF = 0;
  localparam int unsigned OVL_IS_NOP   = 1;
  localparam int unsigned OVL_IS_UNK   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_FIN} st_e;

  typedef struct packed {
    logic ok;
    logic nop;
    logic undef;
    logic spf;
    logic busf;
  } outc_t;

  typedef struct packed {
    logic            match;
    logic [IDXW-1:0] dst_a;
    logic [IDXW-1:0] dst_b;
    logic [IDXW-1:0] base;
    logic            acq;
    logic            tagchk;
    logic            same;
  } dec_t;
endpackage

// File: rtl/lpa_decode.sv
module lpa_decode
  import lpa_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  always_comb begin
    dec.match  = (word[31:21] == OPC_HI) && (word[15:10] == OPC_MID);
    dec.dst_b  = word[20:16];
    dec.base   = word[9:5];
    dec.dst_a  = word[4:0];
    dec.acq    = (dec.dst_a != ZR_IDX) && (dec.dst_b != ZR_IDX);
    dec.tagchk = (dec.base != ZR_IDX);
    dec.same   = (dec.dst_a == dec.dst_b);
  end
endmodule

// File: rtl/lpa_split.sv
module lpa_split #(
  parameter int unsigned XLEN = 64
) (
  input  logic [2*XLEN-1:0] line,
  input  logic              swap,
  output logic [XLEN-1:0]   first,
  output logic [XLEN-1:0]   second
);
  logic [XLEN-1:0] lo_half, hi_half;
  assign lo_half = line[XLEN-1:0];
  assign hi_half = line[2*XLEN-1:XLEN];
  assign first   = swap ? hi_half : lo_half;
  assign second  = swap ? lo_half : hi_half;
endmodule

// File: rtl/lpa_ctrl.sv
module lpa_ctrl
  import lpa_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter int unsigned     OVL_MODE = OVL_IS_UNK,
  parameter logic [XLEN-1:0] UNK_VAL  = {(XLEN/4){4'hA}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic              feat_en,
  input  logic              big_endian,
  input  logic              sp_align_en,
  input  logic [XLEN-1:0]   sp_value,
  input  logic [XLEN-1:0]   rf_rd_data,
  input  logic              instr_valid,
  output logic              instr_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic              mem_req_acquire,
  output logic              mem_req_tagchk,
  input  logic              mem_rsp_valid,
  input  logic [2*XLEN-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              wr0_en,
  output logic [IDXW-1:0]   wr0_idx,
  output logic [XLEN-1:0]   wr0_data,
  output logic              wr1_en,
  output logic [IDXW-1:0]   wr1_idx,
  output logic [XLEN-1:0]   wr1_data,
  output logic              done,
  output outc_t             outc
);
  localparam int unsigned LINE_W   = 2 * XLEN;
  localparam int unsigned ALIGN_LS = $clog2(LINE_W / 8);

  st_e             st;
  logic [IDXW-1:0] dst_a_q, dst_b_q;
  logic            same_q, swap_q, acq_q, tag_q;
  logic [XLEN-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  outc_t           outc_q;

  logic            accept, e_undef, e_nop, e_spf, e_go;
  logic [XLEN-1:0] base_val;
  logic [XLEN-1:0] half_a, half_b;

  assign accept   = (st == ST_IDLE) && instr_valid;
  assign base_val = dec.tagchk ? rf_rd_data : sp_value;

  always_comb begin
    e_undef = !dec.match || !feat_en || (dec.same && OVL_MODE == OVL_IS_UNDEF);
    e_nop   = !e_undef && dec.same && (OVL_MODE == OVL_IS_NOP);
    e_spf   = !e_undef && !e_nop && !dec.tagchk && sp_align_en &&
              (|sp_value[ALIGN_LS-1:0]);
    e_go    = !(e_undef || e_nop || e_spf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      outc_q  <= '0;
      dst_a_q <= '0;
      dst_b_q <= '0;
      same_q  <= 1'b0;
      swap_q  <= 1'b0;
      acq_q   <= 1'b0;
      tag_q   <= 1'b0;
      addr_q  <= '0;
      line_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          dst_a_q <= dec.dst_a;
          dst_b_q <= dec.dst_b;
          same_q  <= dec.same;
          swap_q  <= big_endian;
          acq_q   <= dec.acq;
          tag_q   <= dec.tagchk;
          addr_q  <= base_val;
          if (e_go) st <= ST_REQ;
          else begin
            st     <= ST_FIN;
            outc_q <= '{ok: 1'b0, nop: e_nop, undef: e_undef, spf: e_spf, busf: 1'b0};
          end
        end
        ST_REQ: if (mem_req_ready) st <= ST_RSP;
        ST_RSP: if (mem_rsp_valid) begin
          st     <= ST_FIN;
          line_q <= mem_rsp_data;
          outc_q <= '{ok: !mem_rsp_err, nop: 1'b0, undef: 1'b0, spf: 1'b0, busf: mem_rsp_err};
        end
        ST_FIN: begin
          st     <= ST_IDLE;
          outc_q <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  lpa_split #(.XLEN(XLEN)) u_split (
    .line   (line_q),
    .swap   (swap_q),
    .first  (half_a),
    .second (half_b)
  );

  logic unk_q;
  assign unk_q = same_q && (OVL_MODE == OVL_IS_UNK);

  assign instr_ready     = (st == ST_IDLE);
  assign mem_req_valid   = (st == ST_REQ);
  assign mem_req_addr    = addr_q;
  assign mem_req_acquire = acq_q;
  assign mem_req_tagchk  = tag_q;
  assign done            = (st == ST_FIN);
  assign outc            = outc_q;
  assign wr0_en          = done && outc_q.ok && (dst_a_q != ZR_IDX);
  assign wr1_en          = done && outc_q.ok && (dst_b_q != ZR_IDX);
  assign wr0_idx         = dst_a_q;
  assign wr1_idx         = dst_b_q;
  assign wr0_data        = unk_q ? UNK_VAL : half_a;
  assign wr1_data        = unk_q ? UNK_VAL : half_b;

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(outc) == 1);
  p_quiet_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $countones(outc) == 0);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_acquire) && $stable(mem_req_tagchk)));
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (!mem_req_valid && !done));
  p_zr_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en || wr1_en) |-> ((!wr0_en || wr0_idx != ZR_IDX) && (!wr1_en || wr1_idx != ZR_IDX)));
  p_wr_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en || wr1_en) |-> ($past(mem_rsp_valid) && !$past(mem_rsp_err) && outc.ok));
  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outc.busf |-> (!wr0_en && !wr1_en));
endmodule

// File: rtl/lpa_unit.sv
module lpa_unit
  import lpa_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter int unsigned     OVL_MODE = OVL_IS_UNK,
  parameter logic [XLEN-1:0] UNK_VAL  = {(XLEN/4){4'hA}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              big_endian,
  input  logic              sp_align_en,
  input  logic [XLEN-1:0]   sp_value,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  output logic [IDXW-1:0]   rf_rd_idx,
  input  logic [XLEN-1:0]   rf_rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic              mem_req_acquire,
  output logic              mem_req_tagchk,
  input  logic              mem_rsp_valid,
  input  logic [2*XLEN-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              wr0_en,
  output logic [IDXW-1:0]   wr0_idx,
  output logic [XLEN-1:0]   wr0_data,
  output logic              wr1_en,
  output logic [IDXW-1:0]   wr1_idx,
  output logic [XLEN-1:0]   wr1_data,
  output logic              done,
  output logic              res_ok,
  output logic              res_nop,
  output logic              res_undef,
  output logic              res_sp_fault,
  output logic              res_bus_fault
);
  dec_t  dec;
  outc_t outc;

  lpa_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  assign rf_rd_idx = dec.base;

  lpa_ctrl #(.XLEN(XLEN), .OVL_MODE(OVL_MODE), .UNK_VAL(UNK_VAL)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .dec             (dec),
    .feat_en         (feat_en),
    .big_endian      (big_endian),
    .sp_align_en     (sp_align_en),
    .sp_value        (sp_value),
    .rf_rd_data      (rf_rd_data),
    .instr_valid     (instr_valid),
    .instr_ready     (instr_ready),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_req_acquire (mem_req_acquire),
    .mem_req_tagchk  (mem_req_tagchk),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .mem_rsp_err     (mem_rsp_err),
    .wr0_en          (wr0_en),
    .wr0_idx         (wr0_idx),
    .wr0_data        (wr0_data),
    .wr1_en          (wr1_en),
    .wr1_idx         (wr1_idx),
    .wr1_data        (wr1_data),
    .done            (done),
    .outc            (outc)
  );

  assign res_ok        = outc.ok;
  assign res_nop       = outc.nop;
  assign res_undef     = outc.undef;
  assign res_sp_fault  = outc.spf;
  assign res_bus_fault = outc.busf;
endmodule

// File: tb/lpa_unit_bench.sv
module lpa_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n, feat_en, big_endian, sp_align_en;
  logic [63:0]  sp_value;
  logic         instr_valid, instr_ready;
  logic [31:0]  instr_word;
  logic [4:0]   rf_rd_idx;
  logic [63:0]  rf_rd_data;
  logic         mem_req_valid, mem_req_ready, mem_req_acquire, mem_req_tagchk;
  logic [63:0]  mem_req_addr;
  logic         mem_rsp_valid, mem_rsp_err;
  logic [127:0] mem_rsp_data;
  logic         wr0_en, wr1_en;
  logic [4:0]   wr0_idx, wr1_idx;
  logic [63:0]  wr0_data, wr1_data;
  logic         done, res_ok, res_nop, res_undef, res_sp_fault, res_bus_fault;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [63:0] UNK = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam logic [4:0] O_OK = 5'b10000, O_NOP = 5'b01000, O_UND = 5'b00100,
                         O_SPF = 5'b00010, O_BUS = 5'b00001;

  always #4 clk = ~clk;

  assign rf_rd_data = 64'h4000_0000_0000_0000 | (64'(rf_rd_idx) << 8);

  lpa_unit u_lpa_unit (.*);

  function automatic logic [63:0] reg_val(input logic [4:0] i);
    return 64'h4000_0000_0000_0000 | (64'(i) << 8);
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] b2, input logic [4:0] bs, input logic [4:0] b1);
    return {11'b11011001010, b2, 6'b010110, bs, b1};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    chk("R10 ready while idle", instr_ready, 1'b1);
    instr_valid = 1'b1;
    instr_word  = w;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R10 ready low while busy", instr_ready, 1'b0);
  endtask

  task automatic serve(input string tag, input logic [63:0] addr, input logic acq,
                       input logic tagc, input logic [127:0] data, input logic err);
    chk({tag, " req valid"}, mem_req_valid, 1'b1);
    chk({tag, " addr"}, mem_req_addr, addr);
    chk({tag, " acquire"}, mem_req_acquire, acq);
    chk({tag, " tagchk"}, mem_req_tagchk, tagc);
    @(negedge clk);
    chk("R10 req held under back-pressure", {mem_req_valid, mem_req_addr}, {1'b1, addr});
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R10 req dropped after handshake", mem_req_valid, 1'b0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    mem_rsp_err   = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic finish_op(input string tag, input logic [4:0] oc,
                           input logic e0, input logic [4:0] i0, input logic [63:0] d0,
                           input logic e1, input logic [4:0] i1, input logic [63:0] d1);
    chk({tag, " R11 done"}, done, 1'b1);
    chk({tag, " R11 outcome"}, {res_ok, res_nop, res_undef, res_sp_fault, res_bus_fault}, oc);
    chk({tag, " R9 wr0 en"}, wr0_en, e0);
    chk({tag, " R9 wr1 en"}, wr1_en, e1);
    if (e0) chk({tag, " R9 wr0"}, {wr0_idx, wr0_data}, {i0, d0});
    if (e1) chk({tag, " R9 wr1"}, {wr1_idx, wr1_data}, {i1, d1});
    @(negedge clk);
    chk({tag, " R11 single pulse"}, {done, res_ok, res_nop, res_undef, res_sp_fault, res_bus_fault, wr0_en, wr1_en}, 8'h0);
  endtask

  task automatic t_reset;
    chk("R11 reset done", done, 1'b0);
    chk("R10 reset idle", {instr_ready, mem_req_valid, wr0_en, wr1_en}, 4'b1000);
  endtask

  task automatic t_le_basic;
    send(mk(5'd7, 5'd5, 5'd3));
    serve("R4 R3 gp base", reg_val(5'd5), 1'b1, 1'b1, {64'hBBBB_0002, 64'hAAAA_0001}, 1'b0);
    finish_op("R6 little", O_OK, 1'b1, 5'd3, 64'hAAAA_0001, 1'b1, 5'd7, 64'hBBBB_0002);
  endtask

  task automatic t_be_swap;
    big_endian = 1'b1;
    send(mk(5'd1, 5'd2, 5'd9));
    serve("R4 be", reg_val(5'd2), 1'b1, 1'b1, {64'h1111_2222, 64'h3333_4444}, 1'b0);
    finish_op("R6 big", O_OK, 1'b1, 5'd9, 64'h1111_2222, 1'b1, 5'd1, 64'h3333_4444);
    big_endian = 1'b0;
  endtask

  task automatic t_zero_dest;
    send(mk(5'd6, 5'd4, 5'd31));
    serve("R3 zr dest no acquire", reg_val(5'd4), 1'b0, 1'b1, {64'h66, 64'h55}, 1'b0);
    finish_op("R9 zr discarded", O_OK, 1'b0, 5'd31, 64'h0, 1'b1, 5'd6, 64'h66);
  endtask

  task automatic t_sp_base;
    sp_value = 64'h0000_7FF0_0000_1230;
    send(mk(5'd8, 5'd31, 5'd2));
    serve("R4 sp base", 64'h0000_7FF0_0000_1230, 1'b1, 1'b0, {64'hCC, 64'hDD}, 1'b0);
    finish_op("R4 sp ok", O_OK, 1'b1, 5'd2, 64'hDD, 1'b1, 5'd8, 64'hCC);
  endtask

  task automatic t_sp_fault;
    sp_value = 64'h0000_7FF0_0000_1238;
    send(mk(5'd8, 5'd31, 5'd2));
    chk("R5 no request on misalign", mem_req_valid, 1'b0);
    finish_op("R5 sp fault", O_SPF, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 64'h0);
    sp_align_en = 1'b0;
    send(mk(5'd8, 5'd31, 5'd2));
    serve("R5 check off", 64'h0000_7FF0_0000_1238, 1'b1, 1'b0, {64'h2, 64'h1}, 1'b0);
    finish_op("R5 check off", O_OK, 1'b1, 5'd2, 64'h1, 1'b1, 5'd8, 64'h2);
    sp_align_en = 1'b1;
  endtask

  task automatic t_feat_off;
    feat_en = 1'b0;
    send(mk(5'd7, 5'd5, 5'd3));
    chk("R2 no request", mem_req_valid, 1'b0);
    finish_op("R2 feature off", O_UND, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 64'h0);
    feat_en = 1'b1;
  endtask

  task automatic t_bad_encoding;
    send(mk(5'd7, 5'd5, 5'd3) ^ 32'h0040_0000);
    chk("R1 no request hi", mem_req_valid, 1'b0);
    finish_op("R1 bad bit22", O_UND, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 64'h0);
    send(mk(5'd7, 5'd5, 5'd3) ^ 32'h0000_1000);
    chk("R1 no request mid", mem_req_valid, 1'b0);
    finish_op("R1 bad bit12", O_UND, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 64'h0);
  endtask

  task automatic t_overlap;
    send(mk(5'd4, 5'd10, 5'd4));
    serve("R7 overlap access", reg_val(5'd10), 1'b1, 1'b1, {64'h12, 64'h34}, 1'b0);
    finish_op("R7 overlap unknown", O_OK, 1'b1, 5'd4, UNK, 1'b1, 5'd4, UNK);
  endtask

  task automatic t_bus_err;
    send(mk(5'd7, 5'd5, 5'd3));
    serve("R8 err access", reg_val(5'd5), 1'b1, 1'b1, {64'h9, 64'h8}, 1'b1);
    finish_op("R8 bus fault", O_BUS, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 64'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; feat_en = 1'b1; big_endian = 1'b0; sp_align_en = 1'b1;
    sp_value = '0; instr_valid = 1'b0; instr_word = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_le_basic();
    t_be_swap();
    t_zero_dest();
    t_sp_base();
    t_sp_fault();
    t_feat_off();
    t_bad_encoding();
    t_overlap();
    t_bus_err();
    summary();
    $finish;
  end
endmodule